// File: doc/BRIEF.md
# Transition-Density Loss-of-Signal Monitor

This block watches a serial receive stream that arrives one bit per clock and decides whether the line still carries a usable signal. A bit counts as a transition when it differs from the bit before it. The first bit after reset is compared against a stored zero. A long stretch without any transition declares an internal loss. The internal loss goes away only after the line has shown enough transition density over a fixed-length window.

Two external indication pins are combined into an external loss term. Equal levels on the two pins mean loss, so a signal-detect output of either polarity can be used by strapping the other pin. An active-low enable switches the internal detector off at the output. The combined loss flag blanks the data path: while the flag is high, the forwarded serial bit is held at zero, which tells downstream logic that the line has failed.

Top module: `los_detector`

## Requirements
- R1: With the enable low and no external loss, `los` rises on the bit that follows the 129th consecutive bit without a transition (more than `RUN_LIMIT`=128), and stays low before that.
- R2: Windows of `WIN_LEN`=128 bits run freely from the first bit after reset. An active internal loss clears at the last bit of a window whose transition count is greater than `CLR_MIN`=16, and `los` falls on the next bit. A window with exactly 16 transitions leaves the loss active.
- R3: While `det_en_n` is 1, internal loss does not drive `los`. Internal tracking continues, so a loss that is pending shows on `los` on the first bit after `det_en_n` returns to 0.
- R4: External loss is the XNOR of `ext_los_a` and `ext_los_b`, with 1 meaning loss. It drives `los` in the same cycle, whatever the level of `det_en_n`.
- R5: `los` is the OR of the external loss and the enabled internal loss.
- R6: While `los` is 1, `ser_out` is 0.
- R7: While `los` is 0, `ser_out` equals `ser_in` in the same cycle.
- R8: Every transition restarts the quiet-run count from zero, and a transition never declares loss. After a transition, 128 further quiet bits do not declare loss, and the 129th does.
- R9: After reset the monitor is in the no-loss state, with the run count, the window position and the transition count all at zero. During reset `los` reflects only the external term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Received serial bit |
| det_en_n | input | 1 | Internal detection enable, active low |
| ext_los_a | input | 1 | External indication input A |
| ext_los_b | input | 1 | External indication input B (polarity strap) |
| los | output | 1 | Loss-of-signal flag |
| ser_out | output | 1 | Serial bit, blanked to 0 during loss |

## Verification
A wrong run count shows at `los` as a declaration one or more bits early or late, relative to the last transition. The declaration bit is therefore compared exactly, for several run lengths. A window position or transition count that has drifted does not show until the next window end, which is up to 128 bits later. For that reason the clearing patterns use densities just at the threshold and just above it, and they span several windows. A wrong loss state appears at once on both `los` and `ser_out`, so every bit of every phase is compared against an independently computed expectation.

// File: rtl/losd_pkg.sv
package losd_pkg;
    typedef enum logic {
        LINK_OK   = 1'b0,
        LINK_LOST = 1'b1
    } link_e;
endpackage

// File: rtl/losd_run_track.sv
module losd_run_track #(
    parameter int RUN_LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic trans,
    output logic run_over
);
    localparam int RUN_SAT = RUN_LIMIT + 1;
    localparam int RW      = $clog2(RUN_SAT + 1);

    typedef struct packed {
        logic          prev;
        logic [RW-1:0] run;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = ser_in;
        trans     = ser_in ^ st_q.prev;
        if (trans) begin
            st_d.run = '0;
        end else if (st_q.run != RW'(RUN_SAT)) begin
            st_d.run = st_q.run + 1'b1;
        end
        run_over  = (st_d.run == RW'(RUN_SAT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/losd_win_count.sv
module losd_win_count #(
    parameter int WIN_LEN = 128,
    parameter int CLR_MIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trans,
    output logic win_pass
);
    localparam int WW      = $clog2(WIN_LEN);
    localparam int CNT_SAT = CLR_MIN + 1;
    localparam int CW      = $clog2(CLR_MIN + 3);

    typedef struct packed {
        logic [WW-1:0] pos;
        logic [CW-1:0] cnt;
    } win_st_t;

    win_st_t       st_d, st_q;
    logic          last;
    logic [CW-1:0] total;

    always_comb begin
        st_d     = st_q;
        last     = (st_q.pos == WW'(WIN_LEN - 1));
        total    = st_q.cnt + CW'(trans);
        win_pass = last && (total > CW'(CLR_MIN));
        if (last) begin
            st_d.pos = '0;
            st_d.cnt = '0;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
            st_d.cnt = (total > CW'(CNT_SAT)) ? CW'(CNT_SAT) : total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/los_detector.sv
module los_detector
    import losd_pkg::*;
#(
    parameter int RUN_LIMIT = 128,
    parameter int WIN_LEN   = 128,
    parameter int CLR_MIN   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    input  logic det_en_n,
    input  logic ext_los_a,
    input  logic ext_los_b,
    output logic los,
    output logic ser_out
);
    typedef struct packed {
        link_e link;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    trans_w;
    logic    run_over_w;
    logic    win_pass_w;
    logic    lost_w;
    logic    ext_loss;

    losd_run_track #(.RUN_LIMIT(RUN_LIMIT)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .trans    (trans_w),
        .run_over (run_over_w)
    );

    losd_win_count #(.WIN_LEN(WIN_LEN), .CLR_MIN(CLR_MIN)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .trans    (trans_w),
        .win_pass (win_pass_w)
    );

    always_comb begin
        st_d = st_q;
        if (run_over_w) begin
            st_d.link = LINK_LOST;
        end else if (win_pass_w) begin
            st_d.link = LINK_OK;
        end
        lost_w   = (st_q.link == LINK_LOST);
        ext_loss = ~(ext_los_a ^ ext_los_b);
        los      = ext_loss | (lost_w & ~det_en_n);
        ser_out  = ser_in & ~los;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{link: LINK_OK};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/losd_checker.sv
module losd_checker (
    input logic clk,
    input logic rst_n,
    input logic ser_in,
    input logic det_en_n,
    input logic ext_los_a,
    input logic ext_los_b,
    input logic los,
    input logic ser_out,
    input logic lost,
    input logic trans,
    input logic win_pass
);
    assert_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        los |-> !ser_out);

    assert_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !los |-> (ser_out == ser_in));

    assert_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_los_a == ext_los_b) |-> los);

    assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en_n && (ext_los_a != ext_los_b)) |-> !los);

    assert_set_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> !$past(trans));

    assert_clear_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lost) |-> $past(win_pass));

    assert_edge_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trans && !lost) |=> !lost);
endmodule

bind los_detector losd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .det_en_n  (det_en_n),
    .ext_los_a (ext_los_a),
    .ext_los_b (ext_los_b),
    .los       (los),
    .ser_out   (ser_out),
    .lost      (lost_w),
    .trans     (trans_w),
    .win_pass  (win_pass_w)
);

// File: tb/los_detector_bench.sv
module los_detector_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n     = 1'b0;
    logic ser_in    = 1'b0;
    logic det_en_n  = 1'b0;
    logic ext_los_a = 1'b1;
    logic ext_los_b = 1'b0;
    logic los;
    logic ser_out;

    los_detector u_los_detector (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .det_en_n  (det_en_n),
        .ext_los_a (ext_los_a),
        .ext_los_b (ext_los_b),
        .los       (los),
        .ser_out   (ser_out)
    );

    typedef struct {
        logic  los;
        logic  dat;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;

    // Reference state, derived from the requirements
    logic m_prev;
    int   m_run;
    int   m_cnt;
    int   m_win;
    logic m_lost;
    logic cur_en_n = 1'b0;
    logic cur_a    = 1'b1;
    logic cur_b    = 1'b0;

    task automatic model_reset();
        m_prev = 1'b0;
        m_run  = 0;
        m_cnt  = 0;
        m_win  = 0;
        m_lost = 1'b0;
    endtask

    task automatic set_mode(input logic en_n, input logic a, input logic b);
        cur_en_n = en_n;
        cur_a    = a;
        cur_b    = b;
    endtask

    task automatic step(input logic b, input string tag);
        exp_t e;
        logic tr;
        logic ext;
        int   tot;
        logic over;
        logic pass;
        @(negedge clk);
        rst_n     = 1'b1;
        ser_in    = b;
        det_en_n  = cur_en_n;
        ext_los_a = cur_a;
        ext_los_b = cur_b;
        ext   = ~(cur_a ^ cur_b);
        e.los = ext | (m_lost & ~cur_en_n);
        e.dat = b & ~e.los;
        e.tag = tag;
        exp_q.push_back(e);
        tr   = b ^ m_prev;
        m_run = tr ? 0 : ((m_run < 129) ? m_run + 1 : 129);
        over = (m_run > 128);
        tot  = m_cnt + (tr ? 1 : 0);
        pass = (m_win == 127) && (tot > 16);
        if (over) m_lost = 1'b1;
        else if (pass) m_lost = 1'b0;
        m_cnt  = (m_win == 127) ? 0 : tot;
        m_win  = (m_win + 1) % 128;
        m_prev = b;
    endtask

    task automatic run_const(input int n, input logic v, input string tag);
        for (int i = 0; i < n; i++) step(v, tag);
    endtask

    task automatic run_period(input int n, input int p, input string tag);
        logic v;
        v = m_prev;
        for (int i = 0; i < n; i++) begin
            if (i % p == 0) v = ~v;
            step(v, tag);
        end
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        ext_los_a = cur_a;
        ext_los_b = cur_b;
        det_en_n  = cur_en_n;
        #2;
        check(los, ~(cur_a ^ cur_b), "R9 los during reset");
        model_reset();
    endtask

    // Monitor: compares every driven bit against its expectation
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_run++;
                if (los !== e.los || ser_out !== e.dat) begin
                    n_fail++;
                    $display("FAIL %s: actual los=%b ser_out=%b expected los=%b ser_out=%b",
                             e.tag, los, ser_out, e.los, e.dat);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        set_mode(1'b0, 1'b1, 1'b0);
        do_reset();
        // R9: fresh start, R7: pass-through on a busy line
        run_period(40, 1, "R7 pass-through");
        // R1: transition then a long quiet run; R6: blanking of ones
        run_const(200, 1'b1, "R1/R6 quiet run declares and blanks");
        // R2: exactly 16 transitions per window does not clear
        run_period(384, 8, "R2 threshold not exceeded");
        // R2: 32 per window clears at a window end
        run_period(256, 4, "R2 clear above threshold");
        // R8: 128 quiet bits after a transition, twice, then one more
        run_const(129, ~m_prev, "R8 128 quiet bits no loss");
        run_const(129, ~m_prev, "R8 run restarts on transition");
        run_const(3, m_prev, "R8/R1 129th quiet bit declares");
        run_period(256, 1, "R2 dense clear");
        // R3: disabled detection masks internal loss, then re-enable
        set_mode(1'b1, 1'b1, 1'b0);
        run_const(200, ~m_prev, "R3 masked while disabled");
        set_mode(1'b0, 1'b1, 1'b0);
        run_const(5, m_prev, "R3 pending loss shows on re-enable");
        run_period(256, 1, "R2 clear after re-enable");
        // R4/R5: external term in all pin combinations
        set_mode(1'b0, 1'b0, 1'b0);
        run_period(10, 1, "R4 ext pins 00 loss");
        set_mode(1'b0, 1'b1, 1'b1);
        run_period(10, 1, "R4 ext pins 11 loss");
        set_mode(1'b1, 1'b0, 1'b0);
        run_period(10, 1, "R4/R5 ext loss with detection off");
        set_mode(1'b0, 1'b0, 1'b1);
        run_period(10, 1, "R5 no ext, no internal");
        // R9: reset mid-run clears the run count
        run_const(100, ~m_prev, "R9 partial run");
        do_reset();
        run_const(100, 1'b0, "R9 counters cleared by reset");
        @(negedge clk);
        #4;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule